// File: doc/BRIEF.md
# Rule-Based Address Decoder with Default Port

This block turns a request address into the index of a destination port. It compares the address against a table of address rules that is supplied at run time. Each rule gives a lower bound, an upper bound and a target port index. All rules are compared in parallel. The decoder reports whether any rule hit, which port was chosen, and whether the request must be answered with a decode error.

A requester can enable a fallback port. When that fallback is enabled, an address that no rule covers is sent to the fallback index, and no error is raised.

The decoder is purely combinational from address to outputs. The clock and reset ports exist only so that the bound checker can observe the configuration over time. The rule table and the fallback inputs may be changed only while no request is valid. Every rule must have a lower bound no larger than its upper bound.

Top module: `addr_decoder`

## Requirements
- R1: A rule hits when the address is greater than or equal to its lower bound and less than its upper bound; the lower bound itself hits.
- R2: An address equal to a rule's upper bound does not hit that rule.
- R3: When several rules hit, the port index comes from the hitting rule with the highest table position, regardless of range size.
- R4: Two or more rules may name the same port, and each routes to it independently.
- R5: A rule whose lower bound equals its upper bound hits no address.
- R6: With a valid request, no rule hit and the fallback disabled, `dec_err_o` is 1 and `hit_o` is 0; `dst_port_o` is not defined in this case.
- R7: With a valid request, no rule hit and the fallback enabled, `dst_port_o` equals `dflt_port_i`, `dec_err_o` is 0 and `hit_o` is 0. A rule hit still takes precedence over the fallback.
- R8: While `req_valid_i` is 0, `hit_o` and `dec_err_o` are 0 and `dst_port_o` is all zeros.
- R9: `hit_o` and `dec_err_o` are never 1 together.
- R10: The rule table and the fallback inputs stay unchanged across consecutive cycles in which a request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; used only by the bound checker |
| rst_ni | input | 1 | Synchronous active-low reset; used only by the bound checker |
| req_valid_i | input | 1 | Request address is valid |
| req_addr_i | input | ADDR_W | Request address |
| rule_lo_i | input | NUM_RULES*ADDR_W | Lower bounds (inclusive); rule k occupies bits [k*ADDR_W +: ADDR_W] |
| rule_hi_i | input | NUM_RULES*ADDR_W | Upper bounds (exclusive); same packing as rule_lo_i |
| rule_port_i | input | NUM_RULES*PORT_W | Target port for each rule; rule k at [k*PORT_W +: PORT_W] |
| dflt_en_i | input | 1 | Route unmapped addresses to the fallback port |
| dflt_port_i | input | PORT_W | Fallback port index |
| dst_port_o | output | PORT_W | Selected destination port |
| hit_o | output | 1 | A rule covers the valid request |
| dec_err_o | output | 1 | Valid request is unmapped and has no fallback |

## Verification
The hardest situation to reach from the ports is an address that sits in two overlapping rules at once, one bound away from leaving the inner rule. Here one address picks the higher-positioned rule, and the next address must fall back to the lower one and not to the error path. The stimulus reaches this by loading the table twice with the same two nested ranges in swapped positions. It then probes the first and last covered address and the excluded upper bound of each range. A rule placed at the top of the address space probes the all-ones address, where an inclusive upper-bound mistake would show.

// File: rtl/addr_dec_pkg.sv
// Package: shared defaults and helpers for the rule-based address decoder.
// Assumes: nothing; pure constants and functions.
package addr_dec_pkg;

    localparam int unsigned DEF_ADDR_W    = 32;
    localparam int unsigned DEF_NUM_RULES = 4;
    localparam int unsigned DEF_NUM_PORTS = 4;

    // Width of an index able to name n items, never less than one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/addr_rule_cmp.sv
// Module: addr_rule_cmp
// Compares one address against one half-open range [lo, hi).
// Assumes: lo <= hi (checked by the bound checker while a request is valid).
module addr_rule_cmp #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    output logic              hit_o
);

    // Inclusive lower bound, exclusive upper bound.
    always_comb begin
        hit_o = (addr_i >= lo_i) && (addr_i < hi_i);
    end

endmodule

// File: rtl/addr_prio_pick.sv
// Module: addr_prio_pick
// Picks the port of the highest-positioned hitting rule and reports any hit.
// Assumes: hit vector and port table share the same rule ordering.
module addr_prio_pick #(
    parameter int unsigned NUM_RULES = 4,
    parameter int unsigned PORT_W    = 2
) (
    input  logic [NUM_RULES-1:0]        hits_i,
    input  logic [NUM_RULES*PORT_W-1:0] ports_i,
    output logic                        any_o,
    output logic [PORT_W-1:0]           port_o
);

    // Scan upward so a later (higher) hitting rule overwrites an earlier one.
    always_comb begin
        any_o  = 1'b0;
        port_o = '0;
        for (int i = 0; i < int'(NUM_RULES); i++) begin
            if (hits_i[i]) begin
                any_o  = 1'b1;
                port_o = ports_i[i*PORT_W +: PORT_W];
            end
        end
    end

endmodule

// File: rtl/addr_decoder.sv
// Module: addr_decoder (top)
// Maps a request address to a destination port through a runtime rule table,
// with an optional fallback port replacing the decode error.
// Assumes: table and fallback inputs change only while req_valid_i is low;
// every rule has lo <= hi. clk_i/rst_ni serve only the bound checker.
module addr_decoder #(
    parameter int unsigned ADDR_W    = addr_dec_pkg::DEF_ADDR_W,
    parameter int unsigned NUM_RULES = addr_dec_pkg::DEF_NUM_RULES,
    parameter int unsigned NUM_PORTS = addr_dec_pkg::DEF_NUM_PORTS,
    localparam int unsigned PORT_W   = addr_dec_pkg::idx_bits(NUM_PORTS)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        req_valid_i,
    input  logic [ADDR_W-1:0]           req_addr_i,
    input  logic [NUM_RULES*ADDR_W-1:0] rule_lo_i,
    input  logic [NUM_RULES*ADDR_W-1:0] rule_hi_i,
    input  logic [NUM_RULES*PORT_W-1:0] rule_port_i,
    input  logic                        dflt_en_i,
    input  logic [PORT_W-1:0]           dflt_port_i,
    output logic [PORT_W-1:0]           dst_port_o,
    output logic                        hit_o,
    output logic                        dec_err_o
);

    logic [NUM_RULES-1:0] rule_hits;
    logic                 any_hit;
    logic [PORT_W-1:0]    pick_port;
    logic                 unused_clk_rst;

    // Clock and reset are observed only by the bound checker.
    assign unused_clk_rst = clk_i ^ rst_ni;

    // One range comparator per table entry.
    for (genvar g = 0; g < int'(NUM_RULES); g++) begin : g_rule
        addr_rule_cmp #(.ADDR_W(ADDR_W)) cmp_i (
            .addr_i (req_addr_i),
            .lo_i   (rule_lo_i[g*ADDR_W +: ADDR_W]),
            .hi_i   (rule_hi_i[g*ADDR_W +: ADDR_W]),
            .hit_o  (rule_hits[g])
        );
    end

    addr_prio_pick #(.NUM_RULES(NUM_RULES), .PORT_W(PORT_W)) pick_i (
        .hits_i  (rule_hits),
        .ports_i (rule_port_i),
        .any_o   (any_hit),
        .port_o  (pick_port)
    );

    // Qualify with valid and choose between rule hit, fallback and error.
    always_comb begin
        hit_o      = 1'b0;
        dec_err_o  = 1'b0;
        dst_port_o = '0;
        if (req_valid_i) begin
            if (any_hit) begin
                hit_o      = 1'b1;
                dst_port_o = pick_port;
            end else if (dflt_en_i) begin
                dst_port_o = dflt_port_i;
            end else begin
                dec_err_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/addr_dec_chk.sv
// Module: addr_dec_chk
// Bound checker for addr_decoder: configuration sanity and output rules.
// Assumes: synchronous active-low reset on rst_ni.
module addr_dec_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_RULES = 4,
    parameter int unsigned PORT_W    = 2
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        req_valid_i,
    input logic [NUM_RULES*ADDR_W-1:0] rule_lo_i,
    input logic [NUM_RULES*ADDR_W-1:0] rule_hi_i,
    input logic [NUM_RULES*PORT_W-1:0] rule_port_i,
    input logic                        dflt_en_i,
    input logic [PORT_W-1:0]           dflt_port_i,
    input logic [PORT_W-1:0]           dst_port_o,
    input logic                        hit_o,
    input logic                        dec_err_o
);

    logic seen_edge;

    // Marks that at least one clock has passed since reset release.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) seen_edge <= 1'b0;
        else         seen_edge <= 1'b1;
    end

    // Each rule is ordered while a request is valid (R1).
    for (genvar g = 0; g < int'(NUM_RULES); g++) begin : g_ord
        a_r1_rule_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
            req_valid_i |-> (rule_lo_i[g*ADDR_W +: ADDR_W] <= rule_hi_i[g*ADDR_W +: ADDR_W]));
    end

    a_r10_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_edge && req_valid_i && $past(req_valid_i)) |->
        ($stable(rule_lo_i) && $stable(rule_hi_i) && $stable(rule_port_i)
         && $stable(dflt_en_i) && $stable(dflt_port_i)));

    a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_o && dec_err_o));

    a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |-> (!hit_o && !dec_err_o && dst_port_o == '0));

    a_r7_dflt_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && dflt_en_i) |-> !dec_err_o);

    a_r6_err_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_err_o |-> (req_valid_i && !dflt_en_i));

endmodule

bind addr_decoder addr_dec_chk #(
    .ADDR_W(ADDR_W), .NUM_RULES(NUM_RULES), .PORT_W(PORT_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .rule_lo_i   (rule_lo_i),
    .rule_hi_i   (rule_hi_i),
    .rule_port_i (rule_port_i),
    .dflt_en_i   (dflt_en_i),
    .dflt_port_i (dflt_port_i),
    .dst_port_o  (dst_port_o),
    .hit_o       (hit_o),
    .dec_err_o   (dec_err_o)
);

// File: tb/addr_decoder_tb_top.sv
module addr_decoder_tb_top;

    localparam int unsigned AW = 32;
    localparam int unsigned NR = 4;
    localparam int unsigned PW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [NR*AW-1:0] lo = '0;
    logic [NR*AW-1:0] hi = '0;
    logic [NR*PW-1:0] prt = '0;
    logic            den = 1'b0;
    logic [PW-1:0]   dport = '0;
    logic [PW-1:0]   dst;
    logic            hit;
    logic            err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_decoder #(.ADDR_W(AW), .NUM_RULES(NR), .NUM_PORTS(4)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_addr_i(addr),
        .rule_lo_i(lo), .rule_hi_i(hi), .rule_port_i(prt),
        .dflt_en_i(den), .dflt_port_i(dport),
        .dst_port_o(dst), .hit_o(hit), .dec_err_o(err)
    );

    // Compare outputs; port compared only when chk_port is set.
    task automatic expect_out(input string tag, input logic e_hit, input logic e_err,
                              input logic [PW-1:0] e_port, input bit chk_port);
        n_chk++;
        if (hit !== e_hit || err !== e_err || (chk_port && dst !== e_port)) begin
            n_bad++;
            $display("FAIL %s addr=%h: hit=%b err=%b port=%0d, expected hit=%b err=%b port=%0d",
                     tag, addr, hit, err, dst, e_hit, e_err, e_port);
        end
        n_chk++;
        if (hit === 1'b1 && err === 1'b1) begin
            n_bad++;
            $display("FAIL R9 addr=%h: hit=1 err=1, expected not both", addr);
        end
    endtask

    task automatic set_rule(input int k, input logic [AW-1:0] l, input logic [AW-1:0] h,
                            input logic [PW-1:0] p);
        lo[k*AW +: AW]  = l;
        hi[k*AW +: AW]  = h;
        prt[k*PW +: PW] = p;
    endtask

    // Config changes happen with valid low, then one clock passes.
    task automatic quiesce();
        @(negedge clk);
        valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic probe(input logic [AW-1:0] a);
        @(negedge clk);
        valid = 1'b1;
        addr  = a;
        #1;
    endtask

    task automatic load_table_a();
        quiesce();
        set_rule(0, 32'h1000, 32'h2000, 2'd1);
        set_rule(1, 32'h1800, 32'h1C00, 2'd2);
        set_rule(2, 32'h3000, 32'h3000, 2'd3);
        set_rule(3, 32'h4000, 32'h5000, 2'd1);
        den = 1'b0; dport = 2'd0;
        @(negedge clk);
    endtask

    task automatic t_idle();
        quiesce();
        addr = 32'h1000; #1;
        expect_out("R8 idle", 1'b0, 1'b0, 2'd0, 1'b1);
    endtask

    task automatic t_bounds();
        load_table_a();
        probe(32'h1000); expect_out("R1 lower bound", 1'b1, 1'b0, 2'd1, 1'b1);
        probe(32'h1FFF); expect_out("R1 last inside", 1'b1, 1'b0, 2'd1, 1'b1);
        probe(32'h2000); expect_out("R2 upper excluded", 1'b0, 1'b1, 2'd0, 1'b0);
        probe(32'h0FFF); expect_out("R6 below all", 1'b0, 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_overlap();
        load_table_a();
        probe(32'h1800); expect_out("R3 inner wins", 1'b1, 1'b0, 2'd2, 1'b1);
        probe(32'h1BFF); expect_out("R3 inner last", 1'b1, 1'b0, 2'd2, 1'b1);
        probe(32'h1C00); expect_out("R2 inner end to outer", 1'b1, 1'b0, 2'd1, 1'b1);
        probe(32'h4800); expect_out("R4 shared port", 1'b1, 1'b0, 2'd1, 1'b1);
        probe(32'h3000); expect_out("R5 empty rule", 1'b0, 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_swapped();
        quiesce();
        set_rule(0, 32'h1800, 32'h1C00, 2'd2);
        set_rule(1, 32'h1000, 32'h2000, 2'd0);
        set_rule(2, 32'h0, 32'h0, 2'd0);
        set_rule(3, 32'hFFFF_FF00, 32'hFFFF_FFFF, 2'd3);
        den = 1'b0;
        @(negedge clk);
        probe(32'h1900); expect_out("R3 position beats size", 1'b1, 1'b0, 2'd0, 1'b1);
        probe(32'hFFFF_FFFE); expect_out("R1 top range", 1'b1, 1'b0, 2'd3, 1'b1);
        probe(32'hFFFF_FFFF); expect_out("R2 all-ones excluded", 1'b0, 1'b1, 2'd0, 1'b0);
        probe(32'h0000_0000); expect_out("R5 empty at zero", 1'b0, 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_default();
        load_table_a();
        quiesce();
        den = 1'b1; dport = 2'd3;
        @(negedge clk);
        probe(32'h2000); expect_out("R7 fallback", 1'b0, 1'b0, 2'd3, 1'b1);
        probe(32'h3000); expect_out("R7 fallback on empty rule", 1'b0, 1'b0, 2'd3, 1'b1);
        probe(32'h1800); expect_out("R7 hit beats fallback", 1'b1, 1'b0, 2'd2, 1'b1);
        quiesce();
        dport = 2'd2;
        @(negedge clk);
        probe(32'h9000); expect_out("R7 new fallback index", 1'b0, 1'b0, 2'd2, 1'b1);
        quiesce();
        den = 1'b0;
        @(negedge clk);
        probe(32'h9000); expect_out("R6 fallback disabled", 1'b0, 1'b1, 2'd0, 1'b0);
        quiesce(); #1;
        expect_out("R8 idle after traffic", 1'b0, 1'b0, 2'd0, 1'b1);
        // R10 honoured: every config change above was made with valid low.
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_bounds();
        t_overlap();
        t_swapped();
        t_default();
        quiesce();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule